// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block is a register-mapped unit that sends interprocessor interrupt messages. Software first writes the target unit's identifier into the high command word. It then writes the low command word. That second write is itself the send request. The unit captures a complete message and presents it on a valid/ready output interface. The message carries the destination, the vector, the delivery mode, the trigger mode, the assert level and a broadcast flag.

While a message waits for the receiving side, a busy flag is set and software can read it in the low word. When the downstream side takes the message, the flag drops and a new message may be launched. A low-word write that arrives while busy is set is dropped. Its write response is still returned. Typical sequences are an INIT assert followed by an INIT deassert, and then a STARTUP message. For STARTUP, the vector holds the page number of the start address (address shifted right by 12).

Top module: `ipi_cmd_unit`

## Requirements
- R1: After a synchronous active-high reset, both command words read as zero and `msgValid` is low.
- R2: A write to the high word (offset 0x310) is stored in full and read back unchanged. The destination identifier is bits 31:24.
- R3: A write to the low word (offset 0x300) while idle raises `msgValid` on the next cycle. The message fields are set as follows: destination = high[31:24], vector = low[7:0], mode = low[10:8], assert = low[14], level trigger = low[15], broadcast = low[19].
- R4: Bit 12 of a low-word read reflects the live busy flag: 1 while a message is pending, 0 otherwise. The value written to bit 12 is never returned.
- R5: Busy and `msgValid` clear after the clock edge at which `msgValid` and `msgReady` are both high.
- R6: A low-word write while busy is ignored. The stored low word, the pending message and the busy flag stay unchanged.
- R7: While `msgValid` is high and `msgReady` is low, every message field holds steady, even if the high word is rewritten.
- R8: Every write raises `regWrAck` one cycle later. Every read raises `regRdValid` one cycle later, with the data in `regRdData`.
- R9: Mode codes pass through unchanged. Fixed is 000, INIT is 101 (level assert or deassert) and STARTUP is 110 (vector = start page).
- R10: Writes to any other offset change no state and launch nothing. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 32 | Write data |
| regWrAck | output | 1 | Write response, one cycle after the write |
| regRdValid | output | 1 | Read data valid, one cycle after the read |
| regRdData | output | 32 | Read data |
| msgValid | output | 1 | Outgoing message pending |
| msgReady | input | 1 | Downstream accepts the message |
| msgDest | output | 8 | Destination identifier |
| msgVector | output | 8 | Vector or start page |
| msgMode | output | 3 | Delivery mode |
| msgAssert | output | 1 | 1 = assert, 0 = deassert |
| msgLevel | output | 1 | 1 = level triggered, 0 = edge triggered |
| msgBcast | output | 1 | Broadcast to all units, including the sender |

## Verification
Every register response lags its request by exactly one clock edge. An accepted low-word write shows up on `msgValid` and the message fields one edge later. A completed handshake clears busy one edge after the edge where both valid and ready were high. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read half a period after the single rising edge that should produce it. Held-message checks sample over several such cycles with ready low.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W     = 32;
  localparam int BUSY_BIT   = 12;
  localparam int ASSERT_BIT = 14;
  localparam int LEVEL_BIT  = 15;
  localparam int BCAST_BIT  = 19;
  localparam int MODE_LSB   = 8;
  localparam int MODE_W     = 3;
  localparam int VEC_W      = 8;
  localparam int DEST_W     = 8;
  localparam int DEST_LSB   = DATA_W - DEST_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_FIXED   = 3'b000,
    MODE_INIT    = 3'b101,
    MODE_STARTUP = 3'b110
  } ipiMode_e;

  typedef struct packed {
    logic loadHi;
    logic launch;
    logic retire;
    logic readHi;
    logic readLo;
  } ctlStrobes_t;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [VEC_W-1:0]  vector;
    logic [MODE_W-1:0] mode;
    logic              assertLvl;
    logic              levelTrig;
    logic              bcast;
  } ipiMsg_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] LO_OFFSET = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFFSET = 12'h310
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              msgReady,
  output ctlStrobes_t       strobes,
  output logic              busy,
  output logic              wrAck,
  output logic              rdValid
);
  logic hitLo, hitHi;

  assign hitLo = (regAddr == LO_OFFSET);
  assign hitHi = (regAddr == HI_OFFSET);

  always_comb begin
    strobes.loadHi = regWrEn & hitHi;
    strobes.launch = regWrEn & hitLo & ~busy;
    strobes.retire = busy & msgReady;
    strobes.readHi = regRdEn & hitHi;
    strobes.readLo = regRdEn & hitLo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      wrAck   <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      wrAck   <= regWrEn;
      rdValid <= regRdEn;
      if (strobes.launch)      busy <= 1'b1;
      else if (strobes.retire) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_dpath.sv
module ipi_dpath
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic              busy,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] rdData,
  output ipiMsg_t           msg
);
  logic [DATA_W-1:0] hiWord, loWord, loView;

  always_comb begin
    loView           = loWord;
    loView[BUSY_BIT] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiWord <= '0;
      loWord <= '0;
      rdData <= '0;
      msg    <= '0;
    end else begin
      if (strobes.loadHi) hiWord <= regWrData;
      if (strobes.launch) begin
        loWord        <= regWrData;
        msg.dest      <= hiWord[DEST_LSB +: DEST_W];
        msg.vector    <= regWrData[VEC_W-1:0];
        msg.mode      <= regWrData[MODE_LSB +: MODE_W];
        msg.assertLvl <= regWrData[ASSERT_BIT];
        msg.levelTrig <= regWrData[LEVEL_BIT];
        msg.bcast     <= regWrData[BCAST_BIT];
      end
      if (strobes.readHi)      rdData <= hiWord;
      else if (strobes.readLo) rdData <= loView;
      else                     rdData <= '0;
    end
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] LO_OFFSET = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFFSET = 12'h310
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic              regWrAck,
  output logic              regRdValid,
  output logic [31:0]       regRdData,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [7:0]        msgDest,
  output logic [7:0]        msgVector,
  output logic [2:0]        msgMode,
  output logic              msgAssert,
  output logic              msgLevel,
  output logic              msgBcast
);
  ctlStrobes_t strobes;
  ipiMsg_t     msg;
  logic        busy;

  ipi_ctrl #(.ADDR_W(ADDR_W), .LO_OFFSET(LO_OFFSET), .HI_OFFSET(HI_OFFSET)) u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .msgReady(msgReady), .strobes(strobes), .busy(busy), .wrAck(regWrAck),
    .rdValid(regRdValid)
  );

  ipi_dpath u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .busy(busy), .regWrData(regWrData),
    .rdData(regRdData), .msg(msg)
  );

  assign msgValid  = busy;
  assign msgDest   = msg.dest;
  assign msgVector = msg.vector;
  assign msgMode   = msg.mode;
  assign msgAssert = msg.assertLvl;
  assign msgLevel  = msg.levelTrig;
  assign msgBcast  = msg.bcast;
endmodule

// File: rtl/ipi_cmd_checker.sv
module ipi_cmd_checker #(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] LO_OFFSET = 12'h300,
  parameter logic [ADDR_W-1:0] HI_OFFSET = 12'h310
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrAck,
  input logic              regRdValid,
  input logic [31:0]       regRdData,
  input logic              msgValid,
  input logic              msgReady,
  input logic [7:0]        msgDest,
  input logic [7:0]        msgVector,
  input logic [2:0]        msgMode,
  input logic              msgAssert,
  input logic              msgLevel,
  input logic              msgBcast
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msgValid);

  assert_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == LO_OFFSET && !msgValid) |=> msgValid);

  assert_busy_view_R4: assert property (@(posedge clk) disable iff (rst)
    (regRdValid && $past(regRdEn && regAddr == LO_OFFSET)) |-> (regRdData[12] == $past(msgValid)));

  assert_retire_R5: assert property (@(posedge clk) disable iff (rst)
    (msgValid && msgReady) |=> !msgValid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgDest) && $stable(msgVector) &&
      $stable(msgMode) && $stable(msgAssert) && $stable(msgLevel) && $stable(msgBcast)));

  assert_wr_ack_R8: assert property (@(posedge clk) disable iff (rst)
    regWrEn |=> regWrAck);

  assert_rd_valid_R8: assert property (@(posedge clk) disable iff (rst)
    regRdEn |=> regRdValid);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (regRdValid && $past(regRdEn && regAddr != LO_OFFSET && regAddr != HI_OFFSET))
      |-> (regRdData == 32'h0));
endmodule

bind ipi_cmd_unit ipi_cmd_checker #(.ADDR_W(ADDR_W), .LO_OFFSET(LO_OFFSET), .HI_OFFSET(HI_OFFSET)) u_chk (.*);

// File: tb/test_ipi_cmd_unit.sv
module test_ipi_cmd_unit;
  localparam logic [11:0] LO = 12'h300;
  localparam logic [11:0] HI = 12'h310;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0, regRdEn = 1'b0, msgReady = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic regWrAck, regRdValid, msgValid, msgAssert, msgLevel, msgBcast;
  logic [31:0] regRdData;
  logic [7:0] msgDest, msgVector;
  logic [2:0] msgMode;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ipi_cmd_unit i_ipi_cmd_unit (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regWrAck(regWrAck), .regRdValid(regRdValid),
    .regRdData(regRdData), .msgValid(msgValid), .msgReady(msgReady), .msgDest(msgDest),
    .msgVector(msgVector), .msgMode(msgMode), .msgAssert(msgAssert), .msgLevel(msgLevel),
    .msgBcast(msgBcast)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    check(regWrAck === 1'b1, "R8 write ack", {31'b0, regWrAck}, 32'h1);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    check(regRdValid === 1'b1, "R8 read valid", {31'b0, regRdValid}, 32'h1);
    check(regRdData === exp, req, regRdData, exp);
    regRdEn = 1'b0;
  endtask

  task automatic checkMsg(input logic [7:0] d, input logic [7:0] v, input logic [2:0] m,
                          input logic a, input logic l, input logic b, input string req);
    logic [31:0] act, exp;
    act = {9'b0, msgValid, msgDest, msgVector, msgMode, msgAssert, msgLevel, msgBcast};
    exp = {9'b0, 1'b1, d, v, m, a, l, b};
    check(act === exp, req, act, exp);
  endtask

  task automatic retire();
    @(negedge clk);
    msgReady = 1'b1;
    @(negedge clk);
    check(msgValid === 1'b0, "R5 busy clears on handshake", {31'b0, msgValid}, 32'h0);
    msgReady = 1'b0;
  endtask

  task automatic t_reset();
    check(msgValid === 1'b0, "R1 idle after reset", {31'b0, msgValid}, 32'h0);
    readReg(HI, 32'h0, "R1 high word reset");
    readReg(LO, 32'h0, "R1 low word reset");
  endtask

  task automatic t_highReadback();
    writeReg(HI, 32'hAB00_1234);
    readReg(HI, 32'hAB00_1234, "R2 high word readback");
    check(msgValid === 1'b0, "R2 high write launches nothing", {31'b0, msgValid}, 32'h0);
  endtask

  task automatic t_initAssert();
    writeReg(HI, 32'h0500_0000);
    writeReg(LO, 32'h0000_C500);
    checkMsg(8'h05, 8'h00, 3'b101, 1'b1, 1'b1, 1'b0, "R3 R9 INIT assert fields");
    readReg(LO, 32'h0000_D500, "R4 busy visible while pending");
    retire();
    readReg(LO, 32'h0000_C500, "R4 busy clear after delivery");
  endtask

  task automatic t_busyIgnore();
    writeReg(LO, 32'h0008_8500);
    checkMsg(8'h05, 8'h00, 3'b101, 1'b0, 1'b1, 1'b1, "R3 INIT deassert broadcast fields");
    writeReg(LO, 32'h0000_060F);
    checkMsg(8'h05, 8'h00, 3'b101, 1'b0, 1'b1, 1'b1, "R6 write while busy ignored");
    readReg(LO, 32'h0008_9500, "R6 low word unchanged while busy");
    writeReg(HI, 32'h0700_0000);
    repeat (3) @(negedge clk);
    checkMsg(8'h05, 8'h00, 3'b101, 1'b0, 1'b1, 1'b1, "R7 fields held while not ready");
    retire();
  endtask

  task automatic t_startup();
    writeReg(HI, 32'h0300_0000);
    writeReg(LO, 32'h0000_1600 | (32'h0000_7000 >> 12));
    checkMsg(8'h03, 8'h07, 3'b110, 1'b0, 1'b0, 1'b0, "R9 STARTUP page vector");
    retire();
    readReg(LO, 32'h0000_0607, "R4 written bit 12 not returned");
  endtask

  task automatic t_readyHeld();
    @(negedge clk);
    msgReady = 1'b1;
    writeReg(LO, 32'h0000_0041);
    checkMsg(8'h03, 8'h41, 3'b000, 1'b0, 1'b0, 1'b0, "R3 fixed mode launch");
    @(negedge clk);
    check(msgValid === 1'b0, "R5 one-cycle handshake", {31'b0, msgValid}, 32'h0);
    msgReady = 1'b0;
  endtask

  task automatic t_unmapped();
    writeReg(12'h320, 32'hFFFF_FFFF);
    check(msgValid === 1'b0, "R10 unmapped write launches nothing", {31'b0, msgValid}, 32'h0);
    readReg(12'h320, 32'h0, "R10 unmapped read zero");
    readReg(HI, 32'h0300_0000, "R10 high word untouched");
    readReg(LO, 32'h0000_0041, "R10 low word untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_highReadback();
    t_initAssert();
    t_busyIgnore();
    t_startup();
    t_readyHeld();
    t_unmapped();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule